// File: doc/BRIEF.md
# Pixel to Parallel Bus Cycle Packer

This block sits between a pixel stream and the strobe engine of a parallel display bus. Each pixel arrives over a valid/ready handshake. The block cuts it into one or more bus words whose width is the selected data-line count, and hands each word to the strobe engine with the command/data select level. The split follows from the pixel depth and the line count. The bus carries one, two or three words per pixel, or three words for every two pixels when the depth is one and a half times the line count. Wide pixels on narrow buses always go most significant slice first.

A frame is started by loading a pixel count together with an arm strobe. The block takes exactly that many pixels. When the last word of the last pixel has been accepted, it raises a one-cycle frame-done pulse and drops its busy flag. Command words from a separate side input go straight to the bus with the select line low, but only at points where no pixel group is held or being sent. A depth and line-count pair with no valid cycle format raises an error flag, and the block then takes no pixels and no arm.

Top module: `pixel_bus_packer`

## Requirements
- R1: Pixel depth code 0/1/2/3 means 12/16/18/24 bits, and line code 0/1/2/3 means 8/9/12/16 lines. A pair is legal when depth divided by lines is 1, 2 or 3 exactly, or when twice the depth divided by lines is exactly 3. For any other pair, cfg_err is high from the cycle after the codes are applied, pix_ready stays low and arm is ignored.
- R2: When depth equals lines, each pixel gives one bus word holding its depth bits in the low bits, and bus_data bits above the line count are zero.
- R3: When depth is two or three times the line count, each pixel gives that many words, taken from the pixel most significant slice first (for example, 24 bits on 8 lines sends 23:16, then 15:8, then 7:0).
- R4: When twice the depth is three times the line count, each pair of pixels gives three words. These are the first pixel concatenated above the second, sliced most significant first. The middle word therefore holds the low third of the first pixel in its upper half and the high third of the second pixel in its lower half.
- R5: In the 3-for-2 format with an odd pixel count, the last pixel is sent alone as two words, and the lower half of its second word is zero.
- R6: Every pixel word has bus_a0 high. A command word is placed on the bus with bus_a0 low and its data unchanged only while no pixel group is held or being sent; otherwise cmd_ready stays low.
- R7: An arm with a non-zero count while idle sets busy on the next cycle. An arm with a count of zero, or one given while busy, has no effect.
- R8: The cycle after the final word's handshake, frame_done is high for exactly one cycle and busy is low.
- R9: While a pixel word is offered and bus_ready is low, bus_data and bus_a0 hold their values.
- R10: Bits of pix_data above the selected depth have no effect on any bus word.
- R11: After reset, busy, frame_done, bus_valid, pix_ready and cfg_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 2 | Pixel depth code |
| lines_sel | input | 2 | Data-line count code |
| arm | input | 1 | Start strobe for a frame |
| arm_count | input | 24 | Pixels in the frame, sampled with arm |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 24 | Pixel, right-aligned |
| pix_ready | output | 1 | Pixel taken this cycle when valid |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 16 | Command word |
| cmd_ready | output | 1 | Command word taken this cycle when valid |
| bus_valid | output | 1 | Word offered to the strobe engine |
| bus_ready | input | 1 | Strobe engine takes the word |
| bus_data | output | 16 | Bus word, right-aligned to the line count |
| bus_a0 | output | 1 | High for pixel data, low for a command |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame armed and not complete |
| cfg_err | output | 1 | Depth and line-count pair is illegal |

## Verification
The hardest state to reach is the held half-pair in the 3-for-2 format. The first pixel has been taken, the second has not, and a command is waiting. A directed sequence stops the pixel source after one pixel and offers a command with the bus ready, to show the command is refused. It then completes the pair and checks the three words. The odd-count tail and the arm ignored while busy are reached by frames with chosen counts and a mid-frame arm pulse. Random legal configurations with random source gaps and sink stalls cover everything else.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_EMIT = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        FMT_1P1 = 2'd0,
        FMT_2P1 = 2'd1,
        FMT_3P1 = 2'd2,
        FMT_3P2 = 2'd3
    } fmt_e;

    function automatic logic [4:0] depth_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd12;
            2'd1:    return 5'd16;
            2'd2:    return 5'd18;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic [4:0] line_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd8;
            2'd1:    return 5'd9;
            2'd2:    return 5'd12;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/pbp_cfg_decode.sv
module pbp_cfg_decode
    import pbp_pkg::*;
(
    input  logic [1:0] depth_code,
    input  logic [1:0] lines_code,
    output logic       legal,
    output fmt_e       fmt,
    output logic [4:0] dbits,
    output logic [4:0] lbits
);
    logic [5:0] d6;
    logic [5:0] two_d;
    logic [5:0] l6;
    logic [5:0] q1;
    logic [5:0] q2;

    always_comb begin
        dbits = depth_bits(depth_code);
        lbits = line_bits(lines_code);
        d6    = {1'b0, dbits};
        two_d = {dbits, 1'b0};
        l6    = {1'b0, lbits};
        q1    = d6 / l6;
        q2    = two_d / l6;
        legal = 1'b0;
        fmt   = FMT_1P1;
        if ((d6 % l6) == 6'd0) begin
            if (q1 == 6'd1) begin
                legal = 1'b1;
                fmt   = FMT_1P1;
            end else if (q1 == 6'd2) begin
                legal = 1'b1;
                fmt   = FMT_2P1;
            end else if (q1 == 6'd3) begin
                legal = 1'b1;
                fmt   = FMT_3P1;
            end
        end else if ((two_d % l6) == 6'd0 && q2 == 6'd3) begin
            legal = 1'b1;
            fmt   = FMT_3P2;
        end
    end
endmodule

// File: rtl/pbp_group_load.sv
module pbp_group_load #(
    parameter int PIX_W = 24,
    parameter int GRP_W = 48
) (
    input  logic [GRP_W-1:0] grp_cur,
    input  logic [PIX_W-1:0] pix,
    input  logic [4:0]       dbits,
    input  logic             second,
    output logic [GRP_W-1:0] grp_next
);
    localparam int SH_W = $clog2(GRP_W + 1);

    logic [PIX_W-1:0] mask;
    logic [GRP_W-1:0] wide;
    logic [SH_W-1:0]  sh_first;
    logic [SH_W-1:0]  sh_second;

    always_comb begin
        mask      = (PIX_W'(1) << dbits) - PIX_W'(1);
        wide      = GRP_W'(pix & mask);
        sh_first  = SH_W'(GRP_W) - SH_W'(dbits);
        sh_second = sh_first - SH_W'(dbits);
        if (second) begin
            grp_next = grp_cur | (wide << sh_second);
        end else begin
            grp_next = wide << sh_first;
        end
    end
endmodule

// File: rtl/pbp_word_slice.sv
module pbp_word_slice #(
    parameter int GRP_W = 48,
    parameter int BUS_W = 16
) (
    input  logic [GRP_W-1:0] grp,
    input  logic [4:0]       lbits,
    output logic [BUS_W-1:0] word,
    output logic [GRP_W-1:0] grp_rest
);
    localparam int WS_W = $clog2(BUS_W + 1);

    logic [BUS_W-1:0] top;
    logic [WS_W-1:0]  drop;

    always_comb begin
        top      = grp[GRP_W-1 -: BUS_W];
        drop     = WS_W'(BUS_W) - WS_W'(lbits);
        word     = top >> drop;
        grp_rest = grp << lbits;
    end
endmodule

// File: rtl/pixel_bus_packer.sv
module pixel_bus_packer
    import pbp_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int BUS_W = 16,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       depth_sel,
    input  logic [1:0]       lines_sel,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_count,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    output logic             pix_ready,
    input  logic             cmd_valid,
    input  logic [BUS_W-1:0] cmd_data,
    output logic             cmd_ready,
    output logic             bus_valid,
    input  logic             bus_ready,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_a0,
    output logic             frame_done,
    output logic             busy,
    output logic             cfg_err
);
    localparam int GRP_W = 2 * PIX_W;

    typedef struct packed {
        state_e           st;
        logic [CNT_W-1:0] rem;
        logic [GRP_W-1:0] grp;
        logic [1:0]       wleft;
        logic             slot;
        logic             done;
        logic             err;
    } regs_t;

    regs_t r_q;
    regs_t r_d;

    logic             legal;
    fmt_e             fmt;
    logic [4:0]       dbits;
    logic [4:0]       lbits;
    logic [GRP_W-1:0] grp_loaded;
    logic [GRP_W-1:0] grp_rest;
    logic [BUS_W-1:0] px_word;
    logic             cmd_ok;
    logic             pix_fire;

    pbp_cfg_decode u_dec (
        .depth_code (depth_sel),
        .lines_code (lines_sel),
        .legal      (legal),
        .fmt        (fmt),
        .dbits      (dbits),
        .lbits      (lbits)
    );

    pbp_group_load #(.PIX_W(PIX_W), .GRP_W(GRP_W)) u_load (
        .grp_cur  (r_q.grp),
        .pix      (pix_data),
        .dbits    (dbits),
        .second   (r_q.slot),
        .grp_next (grp_loaded)
    );

    pbp_word_slice #(.GRP_W(GRP_W), .BUS_W(BUS_W)) u_slice (
        .grp      (r_q.grp),
        .lbits    (lbits),
        .word     (px_word),
        .grp_rest (grp_rest)
    );

    always_comb begin
        pix_ready = (r_q.st == ST_FILL) && !r_q.err;
        pix_fire  = pix_valid && pix_ready;
        cmd_ok    = (r_q.st != ST_EMIT) && !r_q.slot;
        cmd_ready = cmd_ok && bus_ready;
        bus_valid = (r_q.st == ST_EMIT) || (cmd_valid && cmd_ok);
        bus_a0    = (r_q.st == ST_EMIT);
        bus_data  = (r_q.st == ST_EMIT) ? px_word : cmd_data;
        frame_done = r_q.done;
        busy      = (r_q.st != ST_IDLE);
        cfg_err   = r_q.err;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = !legal;
        case (r_q.st)
            ST_IDLE: begin
                if (arm && (arm_count != '0) && !r_q.err) begin
                    r_d.st   = ST_FILL;
                    r_d.rem  = arm_count;
                    r_d.slot = 1'b0;
                end
            end
            ST_FILL: begin
                if (pix_fire) begin
                    r_d.rem = r_q.rem - CNT_W'(1);
                    r_d.grp = grp_loaded;
                    if (fmt == FMT_3P2 && !r_q.slot && r_q.rem > CNT_W'(1)) begin
                        r_d.slot = 1'b1;
                    end else begin
                        r_d.st   = ST_EMIT;
                        r_d.slot = 1'b0;
                        case (fmt)
                            FMT_1P1: r_d.wleft = 2'd1;
                            FMT_2P1: r_d.wleft = 2'd2;
                            FMT_3P1: r_d.wleft = 2'd3;
                            default: r_d.wleft = r_q.slot ? 2'd3 : 2'd2;
                        endcase
                    end
                end
            end
            ST_EMIT: begin
                if (bus_ready) begin
                    r_d.grp   = grp_rest;
                    r_d.wleft = r_q.wleft - 2'd1;
                    if (r_q.wleft == 2'd1) begin
                        if (r_q.rem == '0) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.st = ST_FILL;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, rem: '0, grp: '0, wleft: 2'd0,
                     slot: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/pbp_checker.sv
module pbp_checker #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_ready,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic [BUS_W-1:0] bus_data,
    input logic             bus_a0,
    input logic             frame_done,
    input logic             busy,
    input logic             cfg_err
);
    AST_ERR_BLOCKS_PIXELS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !pix_ready); // R1

    AST_IDLE_NO_PIXELS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pix_ready); // R7

    AST_CMD_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_a0) |-> cmd_valid); // R6

    AST_CMD_NOT_DURING_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_a0) |-> !cmd_ready); // R6

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_a0 && !bus_ready) |=> (bus_valid && bus_a0 && $stable(bus_data))); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy); // R8

    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> $past(bus_valid && bus_a0 && bus_ready)); // R8
endmodule

bind pixel_bus_packer pbp_checker #(.BUS_W(BUS_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_ready  (pix_ready),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_data   (bus_data),
    .bus_a0     (bus_a0),
    .frame_done (frame_done),
    .busy       (busy),
    .cfg_err    (cfg_err)
);

// File: tb/pixel_bus_packer_tb.sv
module pixel_bus_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  depth_sel = 2'd1;
    logic [1:0]  lines_sel = 2'd3;
    logic        arm = 1'b0;
    logic [23:0] arm_count = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_ready;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [15:0] bus_data;
    logic        bus_a0;
    logic        frame_done;
    logic        busy;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 0;

    logic [23:0] pix_mem [0:255];
    logic [15:0] exp_w [0:1023];
    int          exp_n;

    always #10 clk = ~clk;

    pixel_bus_packer dut_i (
        .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .lines_sel(lines_sel),
        .arm(arm), .arm_count(arm_count), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_data(bus_data), .bus_a0(bus_a0), .frame_done(frame_done),
        .busy(busy), .cfg_err(cfg_err)
    );

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic int dbits_of(input logic [1:0] c);
        case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
    endfunction

    function automatic int lbits_of(input logic [1:0] c);
        case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
    endfunction

    // -1 illegal, else words per pixel 1..3, or 4 meaning three words per pair
    function automatic int fmt_of(input int d, input int l);
        if (d % l == 0 && d / l >= 1 && d / l <= 3) return d / l;
        if ((2 * d) % l == 0 && (2 * d) / l == 3) return 4;
        return -1;
    endfunction

    function automatic logic [15:0] slice_of(input logic [47:0] c, input int total,
                                             input int k, input int l);
        logic [47:0] m;
        m = (48'd1 << l) - 48'd1;
        return 16'((c >> (total - (k + 1) * l)) & m);
    endfunction

    task automatic build_expect(input int d, input int l, input int n);
        int f;
        logic [47:0] mask;
        f = fmt_of(d, l);
        mask = (48'd1 << d) - 48'd1;
        exp_n = 0;
        if (f != 4) begin
            for (int p = 0; p < n; p++) begin
                for (int k = 0; k < f; k++) begin
                    exp_w[exp_n] = slice_of(48'(pix_mem[p]) & mask, d, k, l);
                    exp_n++;
                end
            end
        end else begin
            for (int p = 0; p < n; p += 2) begin
                logic [47:0] c;
                if (p + 1 < n) begin
                    c = ((48'(pix_mem[p]) & mask) << d) | (48'(pix_mem[p + 1]) & mask);
                    for (int k = 0; k < 3; k++) begin
                        exp_w[exp_n] = slice_of(c, 2 * d, k, l);
                        exp_n++;
                    end
                end else begin
                    c = (48'(pix_mem[p]) & mask) << d;
                    for (int k = 0; k < 2; k++) begin
                        exp_w[exp_n] = slice_of(c, 2 * d, k, l);
                        exp_n++;
                    end
                end
            end
        end
    endtask

    task automatic set_cfg(input logic [1:0] dc, input logic [1:0] lc);
        @(negedge clk);
        depth_sel = dc;
        lines_sel = lc;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input logic [1:0] dc, input logic [1:0] lc, input int n,
                             input int rdy_pct, input bit mid_arm, input string req);
        int pi = 0;
        int wi = 0;
        int guard = 0;
        bit stall = 0;
        logic [15:0] held = '0;
        set_cfg(dc, lc);
        for (int p = 0; p < n; p++) pix_mem[p] = 24'($urandom);
        build_expect(dbits_of(dc), lbits_of(lc), n);
        arm = 1'b1;
        arm_count = 24'(n);
        @(negedge clk);
        arm = 1'b0;
        arm_count = '0;
        #1;
        check(busy == 1'b1, "R7 arm sets busy", int'(busy), 1);
        while (wi < exp_n && guard < 20000) begin
            guard++;
            @(negedge clk);
            arm = (mid_arm && guard == 5);
            arm_count = arm ? 24'd99 : 24'd0;
            pix_valid = (pi < n) && ($urandom % 100 < 70);
            pix_data = pix_valid ? pix_mem[pi] : 24'($urandom);
            bus_ready = ($urandom % 100) < rdy_pct;
            #1;
            if (stall)
                check(bus_valid && bus_a0 && bus_data == held, "R9 word held",
                      int'(bus_data), int'(held));
            if (pix_valid && pix_ready) pi++;
            if (bus_valid && bus_a0 && bus_ready) begin
                check(bus_data == exp_w[wi], req, int'(bus_data), int'(exp_w[wi]));
                wi++;
            end
            stall = bus_valid && bus_a0 && !bus_ready;
            held = bus_data;
        end
        @(negedge clk);
        arm = 1'b0;
        pix_valid = 1'b0;
        bus_ready = 1'b0;
        #1;
        check(frame_done == 1'b1 && busy == 1'b0, "R8 done pulse and idle",
              int'({frame_done, busy}), 2);
        check(pi == n, "R7 pixel count honoured", pi, n);
        @(negedge clk);
        #1;
        check(frame_done == 1'b0, "R8 done lasts one cycle", int'(frame_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !frame_done && !bus_valid && !pix_ready && !cfg_err, "R11 reset state",
              int'({busy, frame_done, bus_valid, pix_ready, cfg_err}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        $urandom(32'd1234);

        // R2 R10: one word per pixel, random upper bits on pix_data
        run_frame(2'd1, 2'd3, 20, 60, 0, "R2 R10 16 on 16");
        run_frame(2'd0, 2'd2, 15, 80, 0, "R2 R10 12 on 12");
        // R3: two and three words per pixel
        run_frame(2'd1, 2'd0, 12, 50, 0, "R3 16 on 8");
        run_frame(2'd2, 2'd1, 10, 70, 0, "R3 18 on 9");
        run_frame(2'd3, 2'd0, 10, 60, 0, "R3 24 on 8");
        run_frame(2'd3, 2'd2, 9, 60, 1, "R3 24 on 12 with late arm");
        // R4: three words per pair
        run_frame(2'd0, 2'd0, 8, 60, 0, "R4 12 on 8");
        run_frame(2'd2, 2'd2, 10, 50, 0, "R4 18 on 12");
        run_frame(2'd3, 2'd3, 12, 70, 0, "R4 24 on 16");
        // R5: odd count leaves a lone pixel
        run_frame(2'd3, 2'd3, 7, 60, 0, "R5 24 on 16 odd");
        run_frame(2'd0, 2'd0, 1, 100, 0, "R5 12 on 8 single");

        // R1: illegal pairs
        set_cfg(2'd1, 2'd1);
        #1;
        check(cfg_err == 1'b1, "R1 16 on 9 flagged", int'(cfg_err), 1);
        arm = 1'b1;
        arm_count = 24'd4;
        pix_valid = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        #1;
        check(!busy && !pix_ready, "R1 arm and pixels refused", int'({busy, pix_ready}), 0);
        pix_valid = 1'b0;
        set_cfg(2'd0, 2'd3);
        #1;
        check(cfg_err == 1'b1, "R1 12 on 16 flagged", int'(cfg_err), 1);
        set_cfg(2'd3, 2'd2);
        #1;
        check(cfg_err == 1'b0, "R1 24 on 12 legal", int'(cfg_err), 0);

        // R7: zero count arm ignored
        arm = 1'b1;
        arm_count = 24'd0;
        @(negedge clk);
        arm = 1'b0;
        #1;
        check(busy == 1'b0, "R7 zero count ignored", int'(busy), 0);

        // R6: command while idle
        cmd_valid = 1'b1;
        cmd_data = 16'hA5C3;
        bus_ready = 1'b1;
        #1;
        check(bus_valid && !bus_a0 && bus_data == 16'hA5C3 && cmd_ready, "R6 idle command",
              int'({bus_valid, bus_a0, bus_data}), int'({1'b1, 1'b0, 16'hA5C3}));
        @(negedge clk);
        cmd_valid = 1'b0;
        bus_ready = 1'b0;

        // R6 R4: command refused while half a pair is held, and during pixel words
        set_cfg(2'd0, 2'd0);
        arm = 1'b1;
        arm_count = 24'd2;
        @(negedge clk);
        arm = 1'b0;
        pix_valid = 1'b1;
        pix_data = 24'hF0ABC;
        @(negedge clk);
        pix_valid = 1'b0;
        cmd_valid = 1'b1;
        cmd_data = 16'h1234;
        bus_ready = 1'b1;
        #1;
        check(!bus_valid && !cmd_ready, "R6 command held off by half pair",
              int'({bus_valid, cmd_ready}), 0);
        @(negedge clk);
        bus_ready = 1'b0;
        pix_valid = 1'b1;
        pix_data = 24'h00123;
        @(negedge clk);
        pix_valid = 1'b0;
        bus_ready = 1'b1;
        #1;
        check(bus_a0 && !cmd_ready && bus_data == 16'h00AB, "R6 pixel word wins",
              int'(bus_data), 16'h00AB);
        @(negedge clk);
        #1;
        check(bus_data == 16'h00C1, "R4 middle word", int'(bus_data), 16'h00C1);
        @(negedge clk);
        #1;
        check(bus_data == 16'h0023, "R4 last word", int'(bus_data), 16'h0023);
        @(negedge clk);
        cmd_valid = 1'b0;
        bus_ready = 1'b0;
        #1;
        check(frame_done == 1'b1, "R8 done after pair", int'(frame_done), 1);

        // random legal configurations
        for (int t = 0; t < 12; t++) begin
            logic [1:0] dc;
            logic [1:0] lc;
            do begin
                dc = 2'($urandom);
                lc = 2'($urandom);
            end while (fmt_of(dbits_of(dc), lbits_of(lc)) < 0);
            run_frame(dc, lc, 1 + int'($urandom % 40), 30 + int'($urandom % 70), 0,
                      "R2 R3 R4 R5 random frame");
        end

        summary();
    end
endmodule